// File: doc/BRIEF.md
# 100BASE-TX Transmit Symbol Path

This block turns the nibble stream a MAC presents on its transmit side into the three-level line symbol stream of a 100 Mb/s twisted-pair link. One fast clock drives everything. A bit enable fires once every `BIT_DIV` clock cycles, and every fifth bit enable is a nibble boundary. At each nibble boundary the block samples the data nibble, the frame enable and the error flag. It signals that boundary on `nib_stb_o` so that the source can present the next nibble.

Each sampled nibble becomes one 5-bit code group. Between frames the group is the idle pattern. The first two nibbles of a frame are replaced by the start delimiter pair. Data nibbles pass through the 4-to-5 code table, or become an invalid group when the error flag is set. The end of a frame appends the end delimiter pair. The group is then shifted out most significant bit first and XORed with an 11-bit self-synchronising key stream. The result is converted to NRZI and then to MLT-3, which is presented as a signed 2-bit level.

Two static controls give raw access for test. One passes a 5-bit symbol (error flag as bit 4, nibble as bits 3..0) straight to the serializer. The other sends unscrambled bits to the line coder.

Top module: `tx100_symbol_path`

## Requirements
- R1: `nib_stb_o` is high for exactly one clock cycle every 5*BIT_DIV cycles, first in the cycle before the 5*BIT_DIV-th rising edge after reset release; the inputs are sampled at the edge that ends that cycle.
- R2: One code bit is consumed at every BIT_DIV-th rising edge after reset release. A group sampled at a nibble edge is sent over the next five bit edges, most significant bit first, with no gap between groups.
- R3: After reset, `tx_nrz_o`, `nrzi_o` and `mlt3_o` are zero and `nib_stb_o` is low. The first group sent is IDLE (11111), and IDLE is sent for every nibble sampled with the frame enable low outside a frame end.
- R4: A nibble sampled with the frame enable high while no frame is open is replaced by J (11000), and the following nibble is replaced by K (10001), whatever its inputs.
- R5: Later nibbles with the frame enable high and no error map by value 0..F to 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R6: The first nibble after K or data that is sampled with the frame enable low is sent as T (01101), and the next nibble is sent as R (00111) whatever its inputs. Sampling then returns to the idle state.
- R7: A data nibble sampled with the error flag high is sent as HALT (00100). The error flag has no effect while the frame enable is low and no frame is open.
- R8: With the encoder bypass high, the group is {error flag, nibble} with no delimiters, and the frame state returns to idle.
- R9: The scrambler holds an 11-bit state s, seeded to all ones by reset. At each bit edge it forms key = s[10] XOR s[8], shifts s left with key entering bit 0, and sends code bit XOR key to `tx_nrz_o`.
- R10: With the scrambler bypass high at a bit edge, the code bit reaches `tx_nrz_o` unchanged while the key state still advances.
- R11: At each bit edge `nrzi_o` toggles if the sent bit is 1 and holds if it is 0.
- R12: At each bit edge a sent 1 steps `mlt3_o` through 0, +1, 0, -1 (coded 00, 01, 00, 11) and a 0 holds it; 10 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; bit rate is its rate divided by BIT_DIV |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_i | input | 4 | Transmit nibble |
| txen_i | input | 1 | Frame enable |
| txer_i | input | 1 | Transmit error flag; bit 4 of the raw symbol in encoder bypass |
| byp_enc_i | input | 1 | Skip delimiters and code table |
| byp_scr_i | input | 1 | Skip the key stream XOR |
| nib_stb_o | output | 1 | Nibble boundary; inputs sampled at the following edge |
| tx_nrz_o | output | 1 | Last sent (scrambled) bit |
| nrzi_o | output | 1 | NRZI level |
| mlt3_o | output | 2 | MLT-3 level, two's complement |

## Verification
The nibble edge does two jobs in one cycle: it loads the next code group into the serializer, and it consumes the last bit of the group before. Every nibble in the bench therefore runs back to back, and the bench rebuilds each group from the line bit stream. A lost or repeated boundary bit breaks that rebuilt group and also shifts the key stream for all bits after it. The scrambler bypass is also switched at nibble edges, so that a change of bypass and a group load fall in the same cycle. The bench judges each bit against its own model, using the bypass value in force at that edge.

// File: rtl/tx100_sym_pkg.sv
`timescale 1ns/1ps
package tx100_sym_pkg;
   localparam int NIB_W = 4;
   localparam int CG_W  = NIB_W + 1;

   typedef logic [CG_W-1:0] cg_t;

   localparam cg_t CG_IDLE = 5'b11111;
   localparam cg_t CG_J    = 5'b11000;
   localparam cg_t CG_K    = 5'b10001;
   localparam cg_t CG_T    = 5'b01101;
   localparam cg_t CG_R    = 5'b00111;
   localparam cg_t CG_HALT = 5'b00100;

   typedef enum logic [1:0] {
      FR_IDLE = 2'd0,
      FR_SOF2 = 2'd1,
      FR_DATA = 2'd2,
      FR_EOF2 = 2'd3
   } fr_state_t;

   function automatic cg_t map_nibble(input logic [NIB_W-1:0] n);
      cg_t c;
      case (n)
         4'h0: c = 5'b11110;
         4'h1: c = 5'b01001;
         4'h2: c = 5'b10100;
         4'h3: c = 5'b10101;
         4'h4: c = 5'b01010;
         4'h5: c = 5'b01011;
         4'h6: c = 5'b01110;
         4'h7: c = 5'b01111;
         4'h8: c = 5'b10010;
         4'h9: c = 5'b10011;
         4'hA: c = 5'b10110;
         4'hB: c = 5'b10111;
         4'hC: c = 5'b11010;
         4'hD: c = 5'b11011;
         4'hE: c = 5'b11100;
         default: c = 5'b11101;
      endcase
      return c;
   endfunction
endpackage

// File: rtl/tx100_timebase.sv
`timescale 1ns/1ps
module tx100_timebase #(
   parameter int BIT_DIV = 2,
   parameter int SLOTS   = 5
) (
   input  logic clk,
   input  logic rst_n,
   output logic bit_ce,
   output logic grp_ce
);
   localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

   logic [SLOT_W-1:0] slot_q;

   generate
      if (BIT_DIV < 1) begin : g_bad_div
         $error("BIT_DIV must be at least 1");
      end
      if (SLOTS < 2) begin : g_bad_slots
         $error("SLOTS must be at least 2");
      end

      if (BIT_DIV == 1) begin : g_full_rate
         assign bit_ce = 1'b1;
      end else begin : g_divided
         localparam int DIV_W = $clog2(BIT_DIV);
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BIT_DIV - 1);
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               div_q <= '0;
            else if (div_q == DIV_LAST) div_q <= '0;
            else                      div_q <= div_q + 1'b1;
         end
         assign bit_ce = (div_q == DIV_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (bit_ce) begin
         if (slot_q == SLOT_LAST) slot_q <= '0;
         else                     slot_q <= slot_q + 1'b1;
      end
   end

   assign grp_ce = bit_ce && (slot_q == SLOT_LAST);
endmodule

// File: rtl/tx100_framer.sv
`timescale 1ns/1ps
module tx100_framer
   import tx100_sym_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             grp_ce,
   input  logic [NIB_W-1:0] txd,
   input  logic             txen,
   input  logic             txer,
   input  logic             byp_enc,
   output cg_t              code
);
   fr_state_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      code = CG_IDLE;
      if (byp_enc) begin
         code = {txer, txd};
         st_d = FR_IDLE;
      end else begin
         case (st_q)
            FR_IDLE: begin
               if (txen) begin
                  code = CG_J;
                  st_d = FR_SOF2;
               end
            end
            FR_SOF2: begin
               code = CG_K;
               st_d = FR_DATA;
            end
            FR_DATA: begin
               if (txen) begin
                  code = txer ? CG_HALT : map_nibble(txd);
               end else begin
                  code = CG_T;
                  st_d = FR_EOF2;
               end
            end
            default: begin
               code = CG_R;
               st_d = FR_IDLE;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st_q <= FR_IDLE;
      else if (grp_ce) st_q <= st_d;
   end
endmodule

// File: rtl/tx100_serializer.sv
`timescale 1ns/1ps
module tx100_serializer
   import tx100_sym_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic bit_ce,
   input  logic grp_ce,
   input  cg_t  code,
   output logic bit_o
);
   cg_t sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= CG_IDLE;
      end else if (bit_ce) begin
         if (grp_ce) sr_q <= code;
         else        sr_q <= {sr_q[CG_W-2:0], 1'b0};
      end
   end

   assign bit_o = sr_q[CG_W-1];
endmodule

// File: rtl/tx100_scrambler.sv
`timescale 1ns/1ps
module tx100_scrambler #(
   parameter int                  LEN  = 11,
   parameter int                  TAP  = 9,
   parameter logic [LEN-1:0]      SEED = '1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_ce,
   input  logic bypass,
   input  logic din,
   output logic dout
);
   logic [LEN-1:0] s_q;
   logic           key;

   generate
      if (TAP < 1 || TAP >= LEN) begin : g_bad_tap
         $error("TAP must lie between 1 and LEN-1");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("SEED must be nonzero");
      end
   endgenerate

   assign key  = s_q[LEN-1] ^ s_q[TAP-1];
   assign dout = bypass ? din : (din ^ key);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      s_q <= SEED;
      else if (bit_ce) s_q <= {s_q[LEN-2:0], key};
   end
endmodule

// File: rtl/tx100_line_coder.sv
`timescale 1ns/1ps
module tx100_line_coder (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_ce,
   input  logic       din,
   output logic       nrz_o,
   output logic       nrzi_o,
   output logic [1:0] mlt3_o
);
   logic [1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nrz_o   <= 1'b0;
         nrzi_o  <= 1'b0;
         phase_q <= 2'd0;
      end else if (bit_ce) begin
         nrz_o <= din;
         if (din) begin
            nrzi_o  <= ~nrzi_o;
            phase_q <= phase_q + 2'd1;
         end
      end
   end

   always_comb begin
      case (phase_q)
         2'd1:    mlt3_o = 2'b01;
         2'd3:    mlt3_o = 2'b11;
         default: mlt3_o = 2'b00;
      endcase
   end
endmodule

// File: rtl/tx100_symbol_path.sv
`timescale 1ns/1ps
module tx100_symbol_path #(
   parameter int               BIT_DIV   = 2,
   parameter int               LFSR_LEN  = 11,
   parameter int               LFSR_TAP  = 9,
   parameter logic [LFSR_LEN-1:0] LFSR_SEED = '1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] txd_i,
   input  logic       txen_i,
   input  logic       txer_i,
   input  logic       byp_enc_i,
   input  logic       byp_scr_i,
   output logic       nib_stb_o,
   output logic       tx_nrz_o,
   output logic       nrzi_o,
   output logic [1:0] mlt3_o
);
   import tx100_sym_pkg::*;

   logic bit_ce, grp_ce, ser_bit, scr_bit;
   cg_t  code;

   tx100_timebase #(.BIT_DIV(BIT_DIV), .SLOTS(CG_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .bit_ce(bit_ce), .grp_ce(grp_ce)
   );

   tx100_framer u_fr (
      .clk(clk), .rst_n(rst_n), .grp_ce(grp_ce),
      .txd(txd_i), .txen(txen_i), .txer(txer_i),
      .byp_enc(byp_enc_i), .code(code)
   );

   tx100_serializer u_ser (
      .clk(clk), .rst_n(rst_n), .bit_ce(bit_ce), .grp_ce(grp_ce),
      .code(code), .bit_o(ser_bit)
   );

   tx100_scrambler #(.LEN(LFSR_LEN), .TAP(LFSR_TAP), .SEED(LFSR_SEED)) u_scr (
      .clk(clk), .rst_n(rst_n), .bit_ce(bit_ce), .bypass(byp_scr_i),
      .din(ser_bit), .dout(scr_bit)
   );

   tx100_line_coder u_lc (
      .clk(clk), .rst_n(rst_n), .bit_ce(bit_ce), .din(scr_bit),
      .nrz_o(tx_nrz_o), .nrzi_o(nrzi_o), .mlt3_o(mlt3_o)
   );

   assign nib_stb_o = grp_ce;
endmodule

// File: rtl/tx100_symbol_path_chk.sv
`timescale 1ns/1ps
module tx100_symbol_path_chk #(
   parameter int BIT_DIV = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       nib_stb,
   input logic       tx_nrz,
   input logic       nrzi,
   input logic [1:0] mlt3
);
   localparam int PER   = 5 * BIT_DIV;
   localparam int CNT_W = $clog2(PER + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (nib_stb) cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
   end

   a_r1_stb_period: assert property (@(posedge clk) disable iff (!rst_n)
      nib_stb |-> (cnt_q == CNT_W'(PER - 1)));

   a_r1_stb_not_late: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_W'(PER - 1)) |-> nib_stb);

   a_r11_toggle_needs_one: assert property (@(posedge clk) disable iff (!rst_n)
      (nrzi != $past(nrzi)) |-> tx_nrz);

   a_r12_level_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mlt3 != 2'b10);

   a_r12_moves_with_nrzi: assert property (@(posedge clk) disable iff (!rst_n)
      (mlt3 != $past(mlt3)) == (nrzi != $past(nrzi)));

   a_r12_zero_between: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(mlt3) != 2'b00) && (mlt3 != $past(mlt3))) |-> (mlt3 == 2'b00));
endmodule

bind tx100_symbol_path tx100_symbol_path_chk #(.BIT_DIV(BIT_DIV)) u_chk (
   .clk(clk), .rst_n(rst_n), .nib_stb(nib_stb_o),
   .tx_nrz(tx_nrz_o), .nrzi(nrzi_o), .mlt3(mlt3_o)
);

// File: tb/tx100_symbol_path_bench.sv
`timescale 1ns/1ps
module tx100_symbol_path_bench;
   localparam int DIV = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] txd = '0;
   logic txen = 1'b0, txer = 1'b0, byp_enc = 1'b0, byp_scr = 1'b0;
   logic nib_stb_o, tx_nrz_o, nrzi_o;
   logic [1:0] mlt3_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   tx100_symbol_path #(.BIT_DIV(DIV)) u_tx100_symbol_path (
      .clk(clk), .rst_n(rst_n), .txd_i(txd), .txen_i(txen), .txer_i(txer),
      .byp_enc_i(byp_enc), .byp_scr_i(byp_scr), .nib_stb_o(nib_stb_o),
      .tx_nrz_o(tx_nrz_o), .nrzi_o(nrzi_o), .mlt3_o(mlt3_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // values in force at the last rising edge
   logic s_rst = 1'b0, s_stb = 1'b0, s_en = 1'b0, s_er = 1'b0, s_be = 1'b0, s_bs = 1'b0;
   logic [3:0] s_txd = '0;
   int edge_n = 0;
   always @(posedge clk) begin
      s_rst <= rst_n; s_stb <= nib_stb_o; s_en <= txen; s_er <= txer;
      s_be <= byp_enc; s_bs <= byp_scr; s_txd <= txd;
      edge_n <= rst_n ? edge_n + 1 : 0;
   end

   logic [4:0] tbl [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                            5'b01010, 5'b01011, 5'b01110, 5'b01111,
                            5'b10010, 5'b10011, 5'b10110, 5'b10111,
                            5'b11010, 5'b11011, 5'b11100, 5'b11101};

   bit         bq[$];
   logic [4:0] cq[$];
   string      tq[$];
   logic [10:0] m_s = '1;
   logic       m_nrzi = 1'b0;
   logic [1:0] m_ph = 2'd0;
   int         m_st = 0;
   logic [4:0] g_acc = '0;
   int         g_cnt = 0;

   initial begin
      for (int i = 0; i < 5; i++) bq.push_back(1'b1);
      cq.push_back(5'b11111);
      tq.push_back("R3");
   end

   always @(negedge clk) begin
      if (s_rst && edge_n > 0) begin
         chk(s_stb == ((edge_n % (5*DIV)) == 0), "R1 strobe timing", s_stb, (edge_n % (5*DIV)) == 0);
         if ((edge_n % DIV) == 0 && bq.size() > 0) begin
            bit b, key, sb;
            logic [1:0] em;
            b   = bq.pop_front();
            key = m_s[10] ^ m_s[8];
            m_s = {m_s[9:0], key};
            sb  = s_bs ? b : (b ^ key);
            if (sb) begin m_nrzi = ~m_nrzi; m_ph = m_ph + 2'd1; end
            em = (m_ph == 2'd1) ? 2'b01 : (m_ph == 2'd3) ? 2'b11 : 2'b00;
            chk(tx_nrz_o == sb, s_bs ? "R2 R10 line bit" : "R2 R9 line bit", tx_nrz_o, sb);
            chk(nrzi_o == m_nrzi, "R11 nrzi", nrzi_o, m_nrzi);
            chk(mlt3_o == em && mlt3_o != 2'b10, "R12 mlt3", mlt3_o, em);
            g_acc = {g_acc[3:0], (s_bs ? tx_nrz_o : (tx_nrz_o ^ key))};
            g_cnt++;
            if (g_cnt == 5) begin
               logic [4:0] ec;
               string t;
               ec = cq.pop_front();
               t  = tq.pop_front();
               chk(g_acc == ec, {t, " code group"}, g_acc, ec);
               g_cnt = 0;
            end
         end
         if (s_stb) begin
            logic [4:0] c;
            string t;
            if (s_be) begin
               c = {s_er, s_txd}; t = "R8"; m_st = 0;
            end else begin
               case (m_st)
                  0: if (s_en) begin c = 5'b11000; t = "R4"; m_st = 1; end
                     else begin c = 5'b11111; t = s_er ? "R7" : "R3"; end
                  1: begin c = 5'b10001; t = "R4"; m_st = 2; end
                  2: if (s_en) begin
                        if (s_er) begin c = 5'b00100; t = "R7"; end
                        else begin c = tbl[s_txd]; t = "R5"; end
                     end else begin c = 5'b01101; t = "R6"; m_st = 3; end
                  default: begin c = 5'b00111; t = "R6"; m_st = 0; end
               endcase
            end
            for (int i = 4; i >= 0; i--) bq.push_back(c[i]);
            cq.push_back(c);
            tq.push_back(t);
         end
      end
   end

   task automatic send(input logic en, input logic er, input logic [3:0] d,
                       input logic be, input logic bs);
      txen = en; txer = er; txd = d; byp_enc = be; byp_scr = bs;
      do @(negedge clk); while (!nib_stb_o);
      @(posedge clk);
      #1;
   endtask

   bit done = 1'b0;

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=0 expected=1");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(nib_stb_o == 1'b0, "R3 reset strobe", nib_stb_o, 0);
      chk(tx_nrz_o == 1'b0 && nrzi_o == 1'b0, "R3 reset nrz", {tx_nrz_o, nrzi_o}, 0);
      chk(mlt3_o == 2'b00, "R3 reset mlt3", mlt3_o, 0);
      @(posedge clk); #1 rst_n = 1'b1;

      // idle with error flag toggling: R7 ignored outside frame
      for (int i = 0; i < 3; i++) send(1'b0, i[0], 4'(i), 1'b0, 1'b0);
      // full frame, all nibble values (R4 R5 R6)
      send(1'b1, 1'b0, 4'h5, 1'b0, 1'b0);
      send(1'b1, 1'b0, 4'h5, 1'b0, 1'b0);
      for (int v = 0; v < 16; v++) send(1'b1, 1'b0, 4'(v), 1'b0, 1'b0);
      for (int i = 0; i < 3; i++) send(1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
      // frame with errors (R7), last nibble in error
      for (int v = 0; v < 10; v++) send(1'b1, v[0] | (v == 9), 4'(v), 1'b0, 1'b0);
      send(1'b0, 1'b1, 4'h3, 1'b0, 1'b0);
      send(1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
      // one-nibble frame, then re-open during the R slot
      send(1'b1, 1'b0, 4'hA, 1'b0, 1'b0);
      send(1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
      send(1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
      send(1'b1, 1'b0, 4'h0, 1'b0, 1'b0);
      for (int v = 0; v < 4; v++) send(1'b1, 1'b0, 4'(v), 1'b0, 1'b0);
      send(1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
      send(1'b1, 1'b0, 4'hC, 1'b0, 1'b0);
      for (int v = 0; v < 3; v++) send(1'b1, 1'b0, 4'(v), 1'b0, 1'b0);
      // scrambler bypassed for a whole frame (R10)
      for (int v = 0; v < 16; v++) send(v < 14, 1'b0, 4'(v), 1'b0, 1'b1);
      // scrambler bypass toggled at every nibble edge mid-frame
      for (int v = 0; v < 20; v++) send(v < 17, v == 8, 4'(v), 1'b0, v[0]);
      // raw symbol sweep, both scrambler settings (R8), entered mid-frame
      send(1'b1, 1'b0, 4'h1, 1'b0, 1'b0);
      send(1'b1, 1'b0, 4'h1, 1'b0, 1'b0);
      for (int s = 0; s < 2; s++)
         for (int v = 0; v < 32; v++) send(v[2], v[4], 4'(v), 1'b1, s[0]);
      // framing resumes from idle after bypass
      for (int v = 0; v < 6; v++) send(v < 4, 1'b0, 4'(v + 7), 1'b0, 1'b0);
      for (int i = 0; i < 4; i++) send(1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
      repeat (5 * DIV + 2) @(posedge clk);
      done = 1'b1;
      finish_run();
   end
endmodule